// File: doc/BRIEF.md
# Shared-Bus Serial Configuration Port

This block is the configuration front end of a two-sided voice channel processor. A host drives a write-only three-wire bus (active-low select, serial clock, serial data) that is wired in parallel to as many as 64 such blocks. Each block tells itself apart by six static strap inputs. The opening byte of a transfer carries a target address and a side-select bit. Only the block whose straps match takes the bytes that follow, and it writes them into the control, input-slot and output-slot registers of side X or side Y.

All three bus pins are brought into the system clock domain through synchronizers, and the serial clock is detected by its edges. Bytes are assembled least significant bit first. The register contents of both sides drive registered outputs. An update flag is high while a matched transfer is open, so that the data path can float its outputs. A standby flag is high when both sides are idle. The algorithm-reset bit clears itself when the processing side reports, with a one-cycle pulse, that the channel reset has finished.

When the mode strap is low the serial port is shut off. The per-side coding, law and idle settings then come straight from the address straps and the two spare bus pins, and every slot number reads as zero.

Top module: `mdrop_cfg_port`

## Requirements
- R1: While port_csn is low, port_sdi is sampled at each rising edge of port_sclk, and eight samples form one byte with the first sample as bit 0. Raising port_csn ends the transfer and restarts the bit and byte counts.
- R2: The first byte is accepted only if bits 5..0 equal addr_strap and bit 7 is 0. Otherwise every later byte of that transfer leaves all registers unchanged.
- R3: In an accepted first byte, bit 6 selects the side: 1 selects X (index 1 of every per-side output) and 0 selects Y (index 0). Bytes two, three and four go to that side's control register, input slot and output slot, in that order.
- R4: A register is written only when all 8 bits of its byte have arrived. A 2-byte transfer changes only the control register, and a partial trailing byte changes nothing.
- R5: Bytes after the fourth in a transfer are ignored until port_csn goes high. They are not taken as a new address byte.
- R6: Control byte fields: bit 5 idle, bit 4 algorithm reset, bit 3 bypass, bit 2 law (1 = mu-law), bit 0 coding direction (1 = compress). Bits 7, 6 and 1 are dropped. A slot byte stores bits 5..0 and drops bits 7 and 6.
- R7: Reset sets idle on both sides and clears every other field, slot, updating and alg_rst. standby is high exactly when both idle bits are set.
- R8: alg_rst of a side is cleared by a one-cycle pulse on that side's bit of alg_done. A pulse on the other side's bit has no effect.
- R9: updating goes high after an accepted address byte and falls once port_csn is high. It never rises for a transfer that is not accepted.
- R10: With sw_mode low the serial port is disabled. X takes compress from addr_strap[0] and law from addr_strap[2]. Y takes compress from addr_strap[3] and law from addr_strap[5]. X idle follows port_csn and Y idle follows port_sdi. Bypass and algorithm reset are 0, and all slots are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_mode | input | 1 | Mode strap: 1 = serial port, 0 = settings from pins |
| addr_strap | input | 6 | Device address straps; in pin mode, coding and law inputs |
| port_csn | input | 1 | Bus select, active low; in pin mode, X idle |
| port_sclk | input | 1 | Bus serial clock |
| port_sdi | input | 1 | Bus serial data; in pin mode, Y idle |
| alg_done | input | 2 | Algorithm reset finished pulse, [1] = X, [0] = Y |
| idle | output | 2 | Idle/power-down per side |
| alg_rst | output | 2 | Algorithm reset request per side |
| bypass | output | 2 | Bypass per side |
| ulaw | output | 2 | Law select per side, 1 = mu-law |
| compress | output | 2 | Coding direction per side, 1 = compress |
| in_slot | output | 2x6 | Input slot number per side |
| out_slot | output | 2x6 | Output slot number per side |
| updating | output | 1 | Matched register update in progress |
| standby | output | 1 | Both sides idle |

## Verification
The assertions rely on three properties of the bus stimulus. The serial clock holds each level for several system clocks, so every edge is seen after synchronization. Data and select change only while the serial clock is low. alg_done arrives as single-cycle pulses. The bench meets these by holding each serial clock phase for four system clocks and changing data and select only in the low phase. It then waits after each transfer for the synchronizer and commit pipeline to settle before it reads the registered outputs.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  // control byte field positions (decoded by the channel datapath)
  localparam int CTL_IDLE = 5;
  localparam int CTL_ALG  = 4;
  localparam int CTL_BYP  = 3;
  localparam int CTL_LAW  = 2;
  localparam int CTL_DIR  = 0;
  // address/command byte
  localparam int SIDE_BIT = 6;
  localparam int RSV_BIT  = 7;
  // side indices
  localparam int SIDE_Y = 0;
  localparam int SIDE_X = 1;
  localparam int NSIDES = 2;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int STAGES = 2,
  parameter bit INIT   = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q,
  output logic rise
);
  logic [STAGES-1:0] pipe;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe <= {STAGES{INIT}};
      last <= INIT;
    end else begin
      pipe <= {pipe[STAGES-2:0], d};
      last <= pipe[STAGES-1];
    end
  end

  assign q    = pipe[STAGES-1];
  assign rise = pipe[STAGES-1] & ~last;
endmodule

// File: rtl/cfg_shift.sv
module cfg_shift #(
  parameter int BYTE_W    = 8,
  parameter int MAX_BYTES = 4,
  localparam int IDX_W    = $clog2(MAX_BYTES + 1),
  localparam int BIT_W    = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              csn_s,
  input  logic              sclk_rise,
  input  logic              sdi_s,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_data,
  output logic [IDX_W-1:0]  byte_num
);
  logic [BYTE_W-1:0] shreg;
  logic [BIT_W-1:0]  bit_cnt;
  logic [IDX_W-1:0]  idx;
  logic [BYTE_W-1:0] shifted;

  assign shifted = {sdi_s, shreg[BYTE_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst || !enable || csn_s) begin
      bit_cnt   <= '0;
      idx       <= '0;
      byte_vld  <= 1'b0;
      byte_data <= '0;
      byte_num  <= '0;
      shreg     <= '0;
    end else begin
      byte_vld <= 1'b0;
      if (sclk_rise) begin
        shreg <= shifted;
        if (bit_cnt == BIT_W'(BYTE_W - 1)) begin
          bit_cnt <= '0;
          if (idx < IDX_W'(MAX_BYTES)) begin
            byte_vld  <= 1'b1;
            byte_data <= shifted;
            byte_num  <= idx;
            idx       <= idx + 1'b1;
          end
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  // R1
  byte_in_xfer_chk: assert property (@(posedge clk) disable iff (rst)
    byte_vld |-> $past(!csn_s && enable));

  // R5
  byte_cap_chk: assert property (@(posedge clk) disable iff (rst)
    byte_vld |-> (byte_num < IDX_W'(MAX_BYTES)));
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
  import cfg_port_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 6,
  parameter int IDX_W  = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          sw_mode,
  input  logic [ADDR_W-1:0]             addr_strap,
  input  logic                          hw_x_idle,
  input  logic                          hw_y_idle,
  input  logic                          csn_s,
  input  logic                          byte_vld,
  input  logic [BYTE_W-1:0]             byte_data,
  input  logic [IDX_W-1:0]              byte_num,
  input  logic [NSIDES-1:0]             alg_done,
  output logic [NSIDES-1:0]             idle,
  output logic [NSIDES-1:0]             alg_rst,
  output logic [NSIDES-1:0]             bypass,
  output logic [NSIDES-1:0]             ulaw,
  output logic [NSIDES-1:0]             compress,
  output logic [NSIDES-1:0][ADDR_W-1:0] in_slot,
  output logic [NSIDES-1:0][ADDR_W-1:0] out_slot,
  output logic                          updating,
  output logic                          standby
);
  logic              matched;
  logic              side_sel;
  logic [NSIDES-1:0] wr_side;
  logic [NSIDES-1:0] wr_ctl;
  logic [NSIDES-1:0] idle_nxt;
  logic [NSIDES-1:0] hw_comp;
  logic [NSIDES-1:0] hw_law;
  logic [NSIDES-1:0] hw_idle;

  assign hw_comp[SIDE_X] = addr_strap[0];
  assign hw_law[SIDE_X]  = addr_strap[2];
  assign hw_comp[SIDE_Y] = addr_strap[3];
  assign hw_law[SIDE_Y]  = addr_strap[5];
  assign hw_idle[SIDE_X] = hw_x_idle;
  assign hw_idle[SIDE_Y] = hw_y_idle;

  // address match for the open transfer
  always_ff @(posedge clk) begin
    if (rst || !sw_mode || csn_s) begin
      matched  <= 1'b0;
      side_sel <= 1'b0;
    end else if (byte_vld && byte_num == IDX_W'(0)) begin
      matched  <= (byte_data[ADDR_W-1:0] == addr_strap) && !byte_data[RSV_BIT];
      side_sel <= byte_data[SIDE_BIT];
    end
  end

  assign updating = matched;

  genvar s;
  generate
    for (s = 0; s < NSIDES; s++) begin : g_side
      logic              r_idle, r_alg, r_byp, r_law, r_dir;
      logic [ADDR_W-1:0] r_in, r_out;

      assign wr_side[s] = sw_mode && matched && byte_vld && (side_sel == s[0]);
      assign wr_ctl[s]  = wr_side[s] && (byte_num == IDX_W'(1));

      always_comb begin
        if (rst)            idle_nxt[s] = 1'b1;
        else if (!sw_mode)  idle_nxt[s] = hw_idle[s];
        else if (wr_ctl[s]) idle_nxt[s] = byte_data[CTL_IDLE];
        else                idle_nxt[s] = r_idle;
      end

      always_ff @(posedge clk) begin
        r_idle <= idle_nxt[s];
        if (rst) begin
          r_alg <= 1'b0;
          r_byp <= 1'b0;
          r_law <= 1'b0;
          r_dir <= 1'b0;
          r_in  <= '0;
          r_out <= '0;
        end else if (!sw_mode) begin
          r_alg <= 1'b0;
          r_byp <= 1'b0;
          r_law <= hw_law[s];
          r_dir <= hw_comp[s];
          r_in  <= '0;
          r_out <= '0;
        end else begin
          if (wr_ctl[s]) begin
            r_alg <= byte_data[CTL_ALG];
            r_byp <= byte_data[CTL_BYP];
            r_law <= byte_data[CTL_LAW];
            r_dir <= byte_data[CTL_DIR];
          end else if (alg_done[s]) begin
            r_alg <= 1'b0;
          end
          if (wr_side[s] && byte_num == IDX_W'(2)) r_in  <= byte_data[ADDR_W-1:0];
          if (wr_side[s] && byte_num == IDX_W'(3)) r_out <= byte_data[ADDR_W-1:0];
        end
      end

      assign idle[s]     = r_idle;
      assign alg_rst[s]  = r_alg;
      assign bypass[s]   = r_byp;
      assign ulaw[s]     = r_law;
      assign compress[s] = r_dir;
      assign in_slot[s]  = r_in;
      assign out_slot[s] = r_out;

      // R8
      alg_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (alg_done[s] && !wr_ctl[s]) |=> !alg_rst[s]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    standby <= &idle_nxt;
  end

  // R7
  standby_match_chk: assert property (@(posedge clk) disable iff (rst)
    standby == (idle[SIDE_X] && idle[SIDE_Y]));

  // R9
  update_in_xfer_chk: assert property (@(posedge clk) disable iff (rst)
    updating |-> $past(!csn_s));

  // R10
  pin_mode_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !sw_mode |=> (!updating && in_slot == '0 && out_slot == '0 && alg_rst == '0));

  // R6
  slot_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sw_mode && $past(sw_mode) && !$past(byte_vld)) |-> ($stable(in_slot) && $stable(out_slot)));
endmodule

// File: rtl/mdrop_cfg_port.sv
module mdrop_cfg_port
  import cfg_port_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int ADDR_W      = 6,
  parameter int MAX_BYTES   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sw_mode,
  input  logic [ADDR_W-1:0]       addr_strap,
  input  logic                    port_csn,
  input  logic                    port_sclk,
  input  logic                    port_sdi,
  input  logic [1:0]              alg_done,
  output logic [1:0]              idle,
  output logic [1:0]              alg_rst,
  output logic [1:0]              bypass,
  output logic [1:0]              ulaw,
  output logic [1:0]              compress,
  output logic [1:0][ADDR_W-1:0]  in_slot,
  output logic [1:0][ADDR_W-1:0]  out_slot,
  output logic                    updating,
  output logic                    standby
);
  localparam int IDX_W = $clog2(MAX_BYTES + 1);

  logic              csn_s, sclk_s, sdi_s;
  logic              csn_rise_unused, sclk_rise, sdi_rise_unused;
  logic              byte_vld;
  logic [BYTE_W-1:0] byte_data;
  logic [IDX_W-1:0]  byte_num;

  cfg_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync_csn (
    .clk(clk), .rst(rst), .d(port_csn), .q(csn_s), .rise(csn_rise_unused));
  cfg_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_sync_sclk (
    .clk(clk), .rst(rst), .d(port_sclk), .q(sclk_s), .rise(sclk_rise));
  cfg_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_sync_sdi (
    .clk(clk), .rst(rst), .d(port_sdi), .q(sdi_s), .rise(sdi_rise_unused));

  cfg_shift #(.BYTE_W(BYTE_W), .MAX_BYTES(MAX_BYTES)) u_shift (
    .clk(clk), .rst(rst), .enable(sw_mode), .csn_s(csn_s),
    .sclk_rise(sclk_rise), .sdi_s(sdi_s),
    .byte_vld(byte_vld), .byte_data(byte_data), .byte_num(byte_num));

  cfg_regs #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst(rst), .sw_mode(sw_mode), .addr_strap(addr_strap),
    .hw_x_idle(csn_s), .hw_y_idle(sdi_s), .csn_s(csn_s),
    .byte_vld(byte_vld), .byte_data(byte_data), .byte_num(byte_num),
    .alg_done(alg_done), .idle(idle), .alg_rst(alg_rst), .bypass(bypass),
    .ulaw(ulaw), .compress(compress), .in_slot(in_slot), .out_slot(out_slot),
    .updating(updating), .standby(standby));

  // R1
  sclk_edge_chk: assert property (@(posedge clk) disable iff (rst)
    sclk_rise |=> !sclk_rise);
endmodule

// File: tb/mdrop_cfg_port_bench.sv
module mdrop_cfg_port_bench;
  localparam logic [5:0] STRAP = 6'h2A;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sw_mode = 1'b1;
  logic [5:0] addr_strap = STRAP;
  logic port_csn = 1'b1, port_sclk = 1'b0, port_sdi = 1'b0;
  logic [1:0] alg_done = 2'b00;
  logic [1:0] idle, alg_rst, bypass, ulaw, compress;
  logic [1:0][5:0] in_slot, out_slot;
  logic updating, standby;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] exp_ctl [2];
  logic [5:0] exp_in  [2];
  logic [5:0] exp_out [2];

  always #2.5 clk = ~clk;

  mdrop_cfg_port u_mdrop_cfg_port (
    .clk(clk), .rst(rst), .sw_mode(sw_mode), .addr_strap(addr_strap),
    .port_csn(port_csn), .port_sclk(port_sclk), .port_sdi(port_sdi),
    .alg_done(alg_done), .idle(idle), .alg_rst(alg_rst), .bypass(bypass),
    .ulaw(ulaw), .compress(compress), .in_slot(in_slot), .out_slot(out_slot),
    .updating(updating), .standby(standby));

  // {acb, ctrl, in slot, out slot, byte count}
  localparam logic [34:0] VECS [7] = '{
    {8'h6A, 8'h0D, 8'h05, 8'h3F, 3'd4},
    {8'h2A, 8'h04, 8'h11, 8'h22, 3'd4},
    {8'h6A, 8'h01, 8'h33, 8'h33, 3'd2},
    {8'h6B, 8'h20, 8'h01, 8'h02, 3'd4},
    {8'hEA, 8'h24, 8'h03, 8'h04, 3'd4},
    {8'h2A, 8'hCA, 8'hFF, 8'hC0, 3'd4},
    {8'h6A, 8'h04, 8'h07, 8'h19, 3'd3}
  };

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(logic [7:0] v, int nbits);
    for (int b = 0; b < nbits; b++) begin
      port_sclk = 1'b0;
      port_sdi  = v[b];
      tick(4);
      port_sclk = 1'b1;
      tick(4);
    end
    port_sclk = 1'b0;
  endtask

  task automatic open_xfer();
    port_csn = 1'b0;
    tick(4);
  endtask

  task automatic close_xfer();
    port_sclk = 1'b0;
    tick(4);
    port_csn = 1'b1;
    tick(12);
  endtask

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_side(int s, string req);
    logic [7:0] got;
    got = {2'b00, idle[s], alg_rst[s], bypass[s], ulaw[s], 1'b0, compress[s]};
    check(got == exp_ctl[s], req, $sformatf("side %0d control", s), got, exp_ctl[s]);
    check(in_slot[s] == exp_in[s], req, $sformatf("side %0d in slot", s), in_slot[s], exp_in[s]);
    check(out_slot[s] == exp_out[s], req, $sformatf("side %0d out slot", s), out_slot[s], exp_out[s]);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    for (int s = 0; s < 2; s++) begin
      exp_ctl[s] = 8'h20; exp_in[s] = '0; exp_out[s] = '0;
    end
    tick(6);
    rst = 1'b0;
    tick(4);

    // R7 reset state
    check_side(0, "R7");
    check_side(1, "R7");
    check(standby == 1'b1, "R7", "standby after reset", standby, 1);
    check(updating == 1'b0, "R9", "updating after reset", updating, 0);

    // table walk: R2 R3 R4 R6
    for (int i = 0; i < 7; i++) begin
      logic [7:0] acb, ctl, its, ots;
      int n, sd;
      {acb, ctl, its, ots} = VECS[i][34:3];
      n = int'(VECS[i][2:0]);
      open_xfer();
      send_bits(acb, 8);
      if (n >= 2) send_bits(ctl, 8);
      if (n >= 3) send_bits(its, 8);
      if (n >= 4) send_bits(ots, 8);
      close_xfer();
      if (acb[5:0] == STRAP && !acb[7]) begin
        sd = acb[6] ? 1 : 0;
        if (n >= 2) exp_ctl[sd] = ctl & 8'h3D;
        if (n >= 3) exp_in[sd]  = its[5:0];
        if (n >= 4) exp_out[sd] = ots[5:0];
      end
      check_side(0, "R3");
      check_side(1, "R6");
      check(standby == (exp_ctl[0][5] & exp_ctl[1][5]), "R7", "standby", standby,
            exp_ctl[0][5] & exp_ctl[1][5]);
    end

    // R9 updating during matched and unmatched transfers
    open_xfer();
    send_bits(8'h6A, 8);
    tick(6);
    check(updating == 1'b1, "R9", "updating after match", updating, 1);
    close_xfer();
    check(updating == 1'b0, "R9", "updating after csn high", updating, 0);
    open_xfer();
    send_bits(8'h55, 8);
    tick(6);
    check(updating == 1'b0, "R9", "updating on mismatch", updating, 0);
    close_xfer();

    // R4 partial trailing byte dropped
    open_xfer();
    send_bits(8'h6A, 8);
    send_bits(8'h05, 8);
    send_bits(8'h3F, 5);
    close_xfer();
    exp_ctl[1] = 8'h05;
    check_side(1, "R4");

    // R5 bytes beyond the fourth ignored, not re-read as an address
    open_xfer();
    send_bits(8'h2A, 8);
    send_bits(8'h04, 8);
    send_bits(8'h09, 8);
    send_bits(8'h0A, 8);
    send_bits(8'h6A, 8);
    send_bits(8'h08, 8);
    close_xfer();
    exp_ctl[0] = 8'h04; exp_in[0] = 6'h09; exp_out[0] = 6'h0A;
    check_side(0, "R5");
    check_side(1, "R5");

    // R8 algorithm reset self-clear
    open_xfer();
    send_bits(8'h2A, 8);
    send_bits(8'h10, 8);
    close_xfer();
    check(alg_rst == 2'b01, "R8", "alg_rst set", alg_rst, 2'b01);
    alg_done = 2'b10;
    tick(1);
    alg_done = 2'b00;
    tick(2);
    check(alg_rst == 2'b01, "R8", "other side pulse", alg_rst, 2'b01);
    alg_done = 2'b01;
    tick(1);
    alg_done = 2'b00;
    tick(2);
    check(alg_rst == 2'b00, "R8", "alg_rst cleared", alg_rst, 2'b00);

    // R7 standby when both sides idled
    open_xfer(); send_bits(8'h6A, 8); send_bits(8'h20, 8); close_xfer();
    check(standby == 1'b0, "R7", "standby one side idle", standby, 0);
    open_xfer(); send_bits(8'h2A, 8); send_bits(8'h20, 8); close_xfer();
    check(standby == 1'b1, "R7", "standby both idle", standby, 1);

    // R10 pin mode
    sw_mode = 1'b0;
    addr_strap = 6'b100101;
    port_csn = 1'b1; port_sdi = 1'b0;
    tick(8);
    exp_ctl[1] = 8'h25; exp_ctl[0] = 8'h04;
    for (int s = 0; s < 2; s++) begin exp_in[s] = '0; exp_out[s] = '0; end
    check_side(0, "R10");
    check_side(1, "R10");
    check(standby == 1'b0, "R10", "pin standby", standby, 0);
    addr_strap = 6'b001000;
    port_sdi = 1'b1;
    tick(8);
    exp_ctl[1] = 8'h20; exp_ctl[0] = 8'h21;
    check_side(0, "R10");
    check_side(1, "R10");
    check(standby == 1'b1, "R10", "pin standby both", standby, 1);
    check(updating == 1'b0, "R10", "pin updating", updating, 0);

    summary();
  end
endmodule